// File: doc/BRIEF.md
# Pulse-Width Time Code Frame Decoder

This block takes a serial time code in which every symbol is one pulse, and the high time of the pulse carries its meaning: about 2 ms means a binary zero, about 5 ms a binary one, and about 8 ms a position marker. One frame lasts one second and holds 100 symbol slots. The decoder synchronises the code line and times the high phase of every pulse with a saturating counter. It sorts each pulse into one of the three symbol kinds by wide tolerance windows, or rejects it as invalid.

Frame alignment comes from the marker pattern alone. Two markers in a row mark the frame start, and the second of the pair is slot 0. From there every pulse advances the slot count. Markers must then appear at slot 0 and at every slot whose units digit is 9. The time-of-day bits are shifted into a frame register. When the closing marker of a complete, well-formed frame arrives, the decoder publishes seconds, minutes, hours and day-of-year in BCD together with a frame-valid flag. A single-cycle pulse-per-second strobe marks the rising edge of the pulse that follows each double marker.

Any malformed symbol drops lock at once: an invalid width, a marker in a data slot, or a data pulse in a marker slot. The decoder then waits for the next double marker.

Top module: `tcode_frame_decoder`

## Requirements
- R1: After reset, `pps` and `frame_valid` are 0 and all four time fields are 0.
- R2: With C = `CYC_PER_MS` clock cycles per millisecond, a measured high time of H cycles is classified as follows. It is a zero if C ≤ H < 4C, a one if 4C ≤ H < 7C, and a marker if H ≥ 7C.
- R3: A pulse shorter than C cycles is invalid. While locked, an invalid pulse drops lock and clears `frame_valid`.
- R4: The second of two consecutive markers is taken as slot 0, and each later pulse advances the slot by one, up to 99. Markers are expected exactly at slot 0 and at the slots whose units digit is 9.
- R5: Every double marker arms a `pps` strobe. The strobe is one cycle wide and appears SYNC_STAGES clock cycles after the line rises for the next pulse (2 cycles by default).
- R6: Each field is BCD, least significant bit first in slot order. Seconds: units in slots 1–4, tens in 6–8. Minutes: units in 10–13, tens in 15–17. Hours: units in 20–23, tens in 25–26. Day: units in 30–33, tens in 35–38, hundreds in 40–41. On the outputs the tens digit (and for day the hundreds digit) sits above the units digit.
- R7: The fields and `frame_valid` change together, SYNC_STAGES+1 clock cycles after the line falls at the end of the slot-99 marker of a complete locked frame.
- R8: While locked, a marker in a data slot or a non-marker in a marker slot drops lock and clears `frame_valid` with the R7 latency. Lock returns at the next double marker, and `frame_valid` returns after the next complete frame.
- R9: Before lock is acquired, data pulses and isolated markers produce neither `pps` nor `frame_valid`.
- R10: The content of data slots 42–98 has no effect on the published fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_in | input | 1 | Serial pulse-width time code line |
| pps | output | 1 | Single-cycle once-per-second strobe |
| frame_valid | output | 1 | Fields hold the time of the last complete, well-formed frame |
| sec_bcd | output | 7 | Seconds, {tens[2:0], units[3:0]} |
| min_bcd | output | 7 | Minutes, {tens[2:0], units[3:0]} |
| hour_bcd | output | 6 | Hours, {tens[1:0], units[3:0]} |
| day_bcd | output | 10 | Day of year, {hundreds[1:0], tens[3:0], units[3:0]} |

## Verification
Frames with random times and pulse widths jittered around the nominal values show that the tolerance windows and the field mapping hold under timing noise. A frame built only from pulses at the exact edges of each window separates a correct threshold from an off-by-one comparison. A run of data pulses mixed with isolated markers separates real alignment on a double marker from locking on any marker. Three corrupted frames, each followed by a clean one, show that lock is lost and regained: one has a marker in a data slot, one has a data pulse where a marker belongs, and one has a too-short pulse.

// File: rtl/tcode_pkg.sv
`timescale 1ns/1ps
package tcode_pkg;

   typedef enum logic [1:0] {
      SYM_BAD  = 2'd0,
      SYM_ZERO = 2'd1,
      SYM_ONE  = 2'd2,
      SYM_MARK = 2'd3
   } sym_t;

   localparam int SLOTS_PER_FRAME = 100;
   localparam int FIELD_BITS      = 30;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [5:0] hour;
      logic [9:0] day;
   } tod_t;

   // slots that carry time-of-day bits; pads and markers are skipped
   function automatic logic is_field_slot(input int s);
      return (s >= 1  && s <= 4)  || (s >= 6  && s <= 8)  ||
             (s >= 10 && s <= 13) || (s >= 15 && s <= 17) ||
             (s >= 20 && s <= 23) || (s >= 25 && s <= 26) ||
             (s >= 30 && s <= 33) || (s >= 35 && s <= 38) ||
             (s >= 40 && s <= 41);
   endfunction

   // bit 0 of the register holds the earliest field slot
   function automatic tod_t unpack_tod(input logic [FIELD_BITS-1:0] f);
      tod_t t;
      t.sec  = {f[6:4],   f[3:0]};
      t.min  = {f[13:11], f[10:7]};
      t.hour = {f[19:18], f[17:14]};
      t.day  = {f[29:28], f[27:24], f[23:20]};
      return t;
   endfunction

endpackage

// File: rtl/tcode_line_sync.sv
`timescale 1ns/1ps
module tcode_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic level,
   output logic rise,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tcode_line_sync: STAGES must be at least 2");
      end
   endgenerate

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic q;
         if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b0;
               else        q <= line_in;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b0;
               else        q <= g_stage[i-1].q;
            end
         end
      end
   endgenerate

   assign level = g_stage[STAGES-2].q;
   assign rise  =  g_stage[STAGES-2].q & ~g_stage[STAGES-1].q;
   assign fall  = ~g_stage[STAGES-2].q &  g_stage[STAGES-1].q;

endmodule

// File: rtl/tcode_pulse_classifier.sv
`timescale 1ns/1ps
module tcode_pulse_classifier
   import tcode_pkg::*;
#(
   parameter int CYC_PER_MS  = 50000,
   parameter int ZERO_MIN_MS = 1,
   parameter int ONE_MIN_MS  = 4,
   parameter int MARK_MIN_MS = 7,
   parameter int SAT_MS      = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic rise,
   input  logic fall,
   output logic sym_stb,
   output sym_t sym
);

   localparam int SAT_CYC = SAT_MS * CYC_PER_MS;
   localparam int CW      = $clog2(SAT_CYC + 1);
   localparam logic [CW-1:0] SAT_V   = CW'(SAT_CYC);
   localparam logic [CW-1:0] ONE_V   = CW'(1);
   localparam logic [CW-1:0] TH_ZERO = CW'(ZERO_MIN_MS * CYC_PER_MS);
   localparam logic [CW-1:0] TH_ONE  = CW'(ONE_MIN_MS * CYC_PER_MS);
   localparam logic [CW-1:0] TH_MARK = CW'(MARK_MIN_MS * CYC_PER_MS);

   generate
      if (CYC_PER_MS < 1) begin : g_bad_rate
         $error("tcode_pulse_classifier: CYC_PER_MS must be positive");
      end
      if (!(ZERO_MIN_MS >= 1 && ZERO_MIN_MS < ONE_MIN_MS && ONE_MIN_MS < MARK_MIN_MS)) begin : g_bad_order
         $error("tcode_pulse_classifier: thresholds must ascend zero < one < marker");
      end
      if (SAT_MS <= MARK_MIN_MS) begin : g_bad_sat
         $error("tcode_pulse_classifier: SAT_MS must exceed MARK_MIN_MS");
      end
   endgenerate

   logic [CW-1:0] width_cnt;

   // restarts on each rising edge, runs while high, freezes at the fall
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          width_cnt <= '0;
      else if (rise)                       width_cnt <= ONE_V;
      else if (level && width_cnt != SAT_V) width_cnt <= width_cnt + ONE_V;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_stb <= 1'b0;
         sym     <= SYM_BAD;
      end else begin
         sym_stb <= fall;
         if (fall) begin
            if      (width_cnt >= TH_MARK) sym <= SYM_MARK;
            else if (width_cnt >= TH_ONE)  sym <= SYM_ONE;
            else if (width_cnt >= TH_ZERO) sym <= SYM_ZERO;
            else                           sym <= SYM_BAD;
         end
      end
   end

endmodule

// File: rtl/tcode_frame_tracker.sv
`timescale 1ns/1ps
module tcode_frame_tracker
   import tcode_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sym_stb,
   input  sym_t sym,
   input  logic rise,
   output logic pps,
   output logic frame_valid,
   output tod_t tod
);

   localparam int SW = $clog2(SLOTS_PER_FRAME);
   localparam logic [SW-1:0] LAST_V = SW'(SLOTS_PER_FRAME - 1);
   localparam logic [SW-1:0] STEP_V = SW'(1);

   generate
      if (SLOTS_PER_FRAME != 100) begin : g_bad_slots
         $error("tcode_frame_tracker: slot digit logic assumes 100 slots");
      end
   endgenerate

   logic [SW-1:0]         slot, nxt_slot;
   logic [3:0]            ones, nxt_ones;
   logic                  locked, prev_mark, pps_arm;
   logic                  is_mark, dbl, exp_mark, bad;
   logic [FIELD_BITS-1:0] field_sr;

   always_comb begin
      nxt_slot = (slot == LAST_V) ? '0 : slot + STEP_V;
      nxt_ones = (ones == 4'd9) ? 4'd0 : ones + 4'd1;
      exp_mark = (nxt_ones == 4'd9) || (nxt_slot == '0);
      is_mark  = (sym == SYM_MARK);
      dbl      = is_mark & prev_mark;
      bad      = (sym == SYM_BAD) || (is_mark != exp_mark);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot        <= '0;
         ones        <= '0;
         locked      <= 1'b0;
         prev_mark   <= 1'b0;
         pps_arm     <= 1'b0;
         pps         <= 1'b0;
         frame_valid <= 1'b0;
         field_sr    <= '0;
         tod         <= '0;
      end else begin
         pps <= 1'b0;
         if (rise && pps_arm) begin
            pps     <= 1'b1;
            pps_arm <= 1'b0;
         end
         if (sym_stb) begin
            prev_mark <= is_mark;
            if (dbl) begin
               // frame reference: realign to slot 0
               slot    <= '0;
               ones    <= '0;
               locked  <= 1'b1;
               pps_arm <= 1'b1;
               if (locked && nxt_slot != '0) frame_valid <= 1'b0;
            end else if (locked) begin
               if (bad) begin
                  locked      <= 1'b0;
                  frame_valid <= 1'b0;
               end else begin
                  slot <= nxt_slot;
                  ones <= nxt_ones;
                  if (is_field_slot(int'(nxt_slot)))
                     field_sr <= {sym == SYM_ONE, field_sr[FIELD_BITS-1:1]};
                  if (nxt_slot == LAST_V) begin
                     tod         <= unpack_tod(field_sr);
                     frame_valid <= 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/tcode_frame_decoder.sv
`timescale 1ns/1ps
module tcode_frame_decoder
   import tcode_pkg::*;
#(
   parameter int CYC_PER_MS  = 50000,
   parameter int ZERO_MIN_MS = 1,
   parameter int ONE_MIN_MS  = 4,
   parameter int MARK_MIN_MS = 7,
   parameter int SAT_MS      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       code_in,
   output logic       pps,
   output logic       frame_valid,
   output logic [6:0] sec_bcd,
   output logic [6:0] min_bcd,
   output logic [5:0] hour_bcd,
   output logic [9:0] day_bcd
);

   logic lvl, rise, fall, sym_stb;
   sym_t sym;
   tod_t tod;

   tcode_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (code_in),
      .level   (lvl),
      .rise    (rise),
      .fall    (fall)
   );

   tcode_pulse_classifier #(
      .CYC_PER_MS  (CYC_PER_MS),
      .ZERO_MIN_MS (ZERO_MIN_MS),
      .ONE_MIN_MS  (ONE_MIN_MS),
      .MARK_MIN_MS (MARK_MIN_MS),
      .SAT_MS      (SAT_MS)
   ) u_class (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (lvl),
      .rise    (rise),
      .fall    (fall),
      .sym_stb (sym_stb),
      .sym     (sym)
   );

   tcode_frame_tracker u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .sym_stb     (sym_stb),
      .sym         (sym),
      .rise        (rise),
      .pps         (pps),
      .frame_valid (frame_valid),
      .tod         (tod)
   );

   assign sec_bcd  = tod.sec;
   assign min_bcd  = tod.min;
   assign hour_bcd = tod.hour;
   assign day_bcd  = tod.day;

endmodule

// File: rtl/tcode_frame_decoder_chk.sv
`timescale 1ns/1ps
module tcode_frame_decoder_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       code_in,
   input logic       pps,
   input logic       frame_valid,
   input logic [6:0] sec_bcd,
   input logic [6:0] min_bcd,
   input logic [5:0] hour_bcd,
   input logic [9:0] day_bcd
);

   // R1: quiet outputs on the first edge after reset release
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pps && !frame_valid && sec_bcd == '0 && day_bcd == '0));

   // R5: strobe lasts a single cycle
   a_r5_pps_single: assert property (@(posedge clk) disable iff (!rst_n)
      pps |=> !pps);

   // R5: strobe follows a low-to-high step of the code line
   a_r5_pps_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      pps |-> ($past(code_in, SYNC_STAGES) && !$past(code_in, SYNC_STAGES + 1)));

   // R7: fields only move when a complete frame is published
   a_r7_fields_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(sec_bcd) && $stable(min_bcd) && $stable(hour_bcd) && $stable(day_bcd))
      |-> frame_valid);

   // R7: publication follows the falling edge of the closing marker
   a_r7_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_valid) |-> !$past(code_in));

endmodule

bind tcode_frame_decoder tcode_frame_decoder_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .code_in     (code_in),
   .pps         (pps),
   .frame_valid (frame_valid),
   .sec_bcd     (sec_bcd),
   .min_bcd     (min_bcd),
   .hour_bcd    (hour_bcd),
   .day_bcd     (day_bcd)
);

// File: tb/tcode_frame_decoder_test.sv
`timescale 1ns/1ps
module tcode_frame_decoder_test;

   localparam int CPM      = 10;
   localparam int SLOT_CYC = 10 * CPM;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       code_in = 1'b0;
   logic       pps, frame_valid;
   logic [6:0] sec_bcd, min_bcd;
   logic [5:0] hour_bcd;
   logic [9:0] day_bcd;

   tcode_frame_decoder #(.CYC_PER_MS(CPM)) uut (
      .clk(clk), .rst_n(rst_n), .code_in(code_in), .pps(pps),
      .frame_valid(frame_valid), .sec_bcd(sec_bcd), .min_bcd(min_bcd),
      .hour_bcd(hour_bcd), .day_bcd(day_bcd)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int  n_checks = 0, n_fail = 0;
   int  exp_pps_cyc = -1, pps_exp = 0, pps_seen = 0;
   bit  last_mark = 0, pend_pps = 0, exp_valid = 0, done = 0;
   bit  v2, v3;
   logic [6:0] s3, m3;
   logic [5:0] h3;
   logic [9:0] d3;

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && pps) begin
         pps_seen++;
         n_checks++;
         if (cyc != exp_pps_cyc) begin
            n_fail++;
            $display("FAIL R5 pps cycle: actual %0d expected %0d", cyc, exp_pps_cyc);
         end
      end
   end

   // reference classification from the R2/R3 windows
   function automatic int kind_of(input int w);
      if (w >= 7 * CPM) return 3;
      if (w >= 4 * CPM) return 2;
      if (w >= 1 * CPM) return 1;
      return 0;
   endfunction

   function automatic int jit(input int nom_ms);
      return nom_ms * CPM + int'($urandom_range(0, 10)) - 5;
   endfunction

   function automatic int bcd2(input int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction

   function automatic int bcd3(input int v);
      return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
   endfunction

   // R6 slot layout; slots 42..98 are left to random fill (R10)
   function automatic logic [41:0] slot_bits(input int sc, input int mn, input int hr, input int dy);
      logic [41:0] b = '0;
      b[4:1]   = 4'(sc % 10);       b[8:6]   = 3'(sc / 10);
      b[13:10] = 4'(mn % 10);       b[17:15] = 3'(mn / 10);
      b[23:20] = 4'(hr % 10);       b[26:25] = 2'(hr / 10);
      b[33:30] = 4'(dy % 10);       b[38:35] = 4'((dy / 10) % 10);
      b[41:40] = 2'(dy / 100);
      return b;
   endfunction

   task automatic send_slot(input int w);
      int k;
      @(negedge clk);
      code_in = 1'b1;
      if (pend_pps) begin
         exp_pps_cyc = cyc + 2;
         pps_exp++;
         pend_pps = 0;
      end
      repeat (w) @(negedge clk);
      code_in = 1'b0;
      k = kind_of(w);
      pend_pps  = (k == 3) && last_mark;
      last_mark = (k == 3);
      repeat (2) @(negedge clk);
      v2 = frame_valid;
      @(negedge clk);
      v3 = frame_valid;
      s3 = sec_bcd; m3 = min_bcd; h3 = hour_bcd; d3 = day_bcd;
      repeat (SLOT_CYC - w - 4) @(negedge clk);
   endtask

   // kind: 0 clean, 1 marker in data slot, 2 zero in marker slot, 3 short pulse
   task automatic send_frame(input int sc, input int mn, input int hr, input int dy,
                             input int kind, input int cslot, input bit edgew);
      logic [41:0] sb;
      string tag;
      sb  = slot_bits(sc, mn, hr, dy);
      tag = edgew ? "R2 R6" : "R4 R6";
      for (int s = 0; s < 100; s++) begin
         bit mk;
         bit b;
         int w;
         mk = (s == 0) || (s % 10 == 9);
         if (mk) w = edgew ? ((s % 20 == 9) ? 70 : 119) : jit(8);
         else begin
            b = (s < 42) ? sb[s] : 1'($urandom_range(0, 1));
            if (b) w = edgew ? ((s % 2 == 1) ? 40 : 69) : jit(5);
            else   w = edgew ? ((s % 2 == 1) ? 10 : 39) : jit(2);
         end
         if (kind != 0 && s == cslot)
            w = (kind == 1) ? jit(8) : (kind == 2) ? jit(2) : 5;
         send_slot(w);
         if (kind == 0 && s == 99) begin
            check("R7", "valid before publish", v2, exp_valid);
            check("R7", "valid at publish", v3, 1);
            check(tag, "seconds", s3, bcd2(sc));
            check(tag, "minutes", m3, bcd2(mn));
            check(tag, "hours", h3, bcd2(hr));
            check(tag, "day", d3, bcd3(dy));
            exp_valid = 1;
         end
         if (kind != 0 && s == cslot) begin
            check(kind == 3 ? "R3" : "R8", "valid before drop", v2, exp_valid);
            check(kind == 3 ? "R3" : "R8", "valid after drop", v3, 0);
            exp_valid = 0;
         end
      end
   endtask

   task automatic rand_frame(input int kind, input int cslot);
      send_frame(int'($urandom_range(0, 59)), int'($urandom_range(0, 59)),
                 int'($urandom_range(0, 23)), int'($urandom_range(1, 366)), kind, cslot, 1'b0);
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
   endtask

   initial begin
      void'($urandom(32'd9137));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "pps after reset", pps, 0);
      check("R1", "valid after reset", frame_valid, 0);
      check("R1", "seconds after reset", sec_bcd, 0);
      check("R1", "day after reset", day_bcd, 0);

      // R9: data with isolated markers must not lock
      for (int s = 0; s < 30; s++)
         send_slot((s % 4 == 3) ? jit(8) : (($urandom_range(0, 1) != 0) ? jit(5) : jit(2)));
      check("R9", "pps before lock", pps_seen, 0);
      check("R9", "valid before lock", frame_valid, 0);

      send_slot(jit(8));
      rand_frame(0, 0);
      send_frame(59, 59, 23, 366, 0, 0, 1'b0);
      send_frame(7, 30, 12, 199, 0, 0, 1'b1);
      rand_frame(1, 45);
      rand_frame(0, 0);
      rand_frame(2, 59);
      rand_frame(0, 0);
      rand_frame(3, 20);
      rand_frame(0, 0);

      check("R5", "pps count", pps_seen, pps_exp);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      wait (cyc >= 190000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
         $finish;
      end
   end

endmodule